// File: doc/BRIEF.md
# Reversible Pseudorandom Step Counter

This block is a 16-bit shift-register counter that walks a maximal-length pseudorandom sequence of non-zero states, one position per enabled clock, either forward or backward. It takes the place of a binary counter followed by a lookup memory in ranging logic: the register state itself is the count, and software or downstream logic compares states rather than decoding them.

Forward steps shift the register toward the most significant bit and feed the low end with the parity of a fixed tap set. Backward steps shift toward the least significant bit and rebuild the bit that was lost, using the bit just shifted out together with the forward taps displaced by one position. A 2:1 selector in front of every flip-flop picks the neighbour on the correct side, so a backward step exactly undoes a forward step. A parallel load sets any state, and a flag reports when the register holds the seed value.

Top module: `lfsr_updown_ctr`

## Requirements
- R1: With `rst` high at a rising clock edge, the next state is 16'h0001 and `at_seed` is 1.
- R2: With `rst`, `load` and `en` all low, the state and `at_seed` keep their values at the edge, whatever `dir_up` is.
- R3: With `en` high, `dir_up` high, `load` and `rst` low, the next state is {q[14:0], q[15]^q[14]^q[12]^q[3]}, where q is the current state.
- R4: With `en` high, `dir_up` low, `load` and `rst` low, the next state is {q[0]^q[15]^q[13]^q[4], q[15:1]}.
- R5: Any N forward steps followed by N backward steps return the state to its starting value.
- R6: Starting from 16'h0001 and stepping forward continuously, the state first returns to 16'h0001 after exactly 65535 steps.
- R7: With `load` high and `rst` low, the next state is `load_val`, regardless of `en` and `dir_up`; a `load_val` of zero loads 16'h0001 instead.
- R8: After reset, the state is never all zeros.
- R9: `at_seed` is 1 exactly when the state is 16'h0001.
- R10: `rst` takes priority over `load`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset to the seed, active high |
| en | input | 1 | Advance the sequence by one step at this edge |
| dir_up | input | 1 | 1 steps forward, 0 steps backward; sampled with `en` |
| load | input | 1 | Parallel load of `load_val` at this edge |
| load_val | input | 16 | Value for a parallel load |
| state | output | 16 | Current register contents |
| at_seed | output | 1 | High when `state` equals the seed 16'h0001 |

## Verification
The bound checker watches on every cycle the reset value, the hold behaviour, the one-position shift in each direction, the load result including the zero substitution, the absence of the all-zero state and the agreement of the seed flag with the state. Properties of whole trajectories cannot be seen one cycle at a time: that a backward run retraces a forward run of any length and that the forward period is exactly 65535 are shown only by the bench's scenarios, which also compare every step against a behavioural model built from tap lists.

// File: rtl/lfsr_pkg.sv
package lfsr_pkg;

    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2,
        STEP_LOAD = 2'd3
    } step_e;

    // Load wins over stepping; stepping needs enable.
    function automatic step_e pick_step(input logic ld, input logic go, input logic up);
        if (ld)
            return STEP_LOAD;
        else if (go)
            return up ? STEP_UP : STEP_DOWN;
        else
            return STEP_HOLD;
    endfunction

endpackage

// File: rtl/lfsr_tap_xor.sv
module lfsr_tap_xor #(
    parameter int             W    = 16,
    parameter logic [W-1:0]   MASK = '1
) (
    input  logic [W-1:0] vec,
    output logic         par
);
    logic [W-1:0] picked;

    always_comb begin
        picked = vec & MASK;
        par    = ^picked;
    end
endmodule

// File: rtl/lfsr_shift_mux.sv
module lfsr_shift_mux #(
    parameter int W = 16
) (
    input  logic [W-1:0] cur,
    input  logic         fwd_in,
    input  logic         rev_in,
    input  logic         go_up,
    output logic [W-1:0] nxt
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        if (i == 0) begin : g_low
            assign nxt[i] = go_up ? fwd_in : cur[i+1];
        end else if (i == W-1) begin : g_high
            assign nxt[i] = go_up ? cur[i-1] : rev_in;
        end else begin : g_mid
            assign nxt[i] = go_up ? cur[i-1] : cur[i+1];
        end
    end
endmodule

// File: rtl/lfsr_updown_ctr.sv
module lfsr_updown_ctr
    import lfsr_pkg::*;
#(
    parameter int           W        = 16,
    parameter logic [W-1:0] FWD_TAPS = 16'hD008,
    parameter logic [W-1:0] SEED     = 16'h0001
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         dir_up,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] state,
    output logic         at_seed
);
    // Backward taps: forward taps moved up one place, plus the bit shifted out.
    localparam logic [W-1:0] REV_TAPS  = {FWD_TAPS[W-2:0], 1'b1};
    localparam logic [W-1:0] SAFE_SEED = (SEED == '0) ? {{(W-1){1'b0}}, 1'b1} : SEED;

    typedef struct packed {
        logic [W-1:0] lfsr;
        logic         hit;
    } ctr_t;

    ctr_t         cur_q;
    ctr_t         nxt_d;
    step_e        mode_d;
    logic         fwd_bit;
    logic         rev_bit;
    logic [W-1:0] shifted;

    lfsr_tap_xor #(.W(W), .MASK(FWD_TAPS)) u_fwd_fb (
        .vec (cur_q.lfsr),
        .par (fwd_bit)
    );

    lfsr_tap_xor #(.W(W), .MASK(REV_TAPS)) u_rev_fb (
        .vec (cur_q.lfsr),
        .par (rev_bit)
    );

    lfsr_shift_mux #(.W(W)) u_dir_mux (
        .cur    (cur_q.lfsr),
        .fwd_in (fwd_bit),
        .rev_in (rev_bit),
        .go_up  (dir_up),
        .nxt    (shifted)
    );

    always_comb begin
        nxt_d  = cur_q;
        mode_d = pick_step(load, en, dir_up);
        unique case (mode_d)
            STEP_UP,
            STEP_DOWN: nxt_d.lfsr = shifted;
            STEP_LOAD: nxt_d.lfsr = (load_val == '0) ? SAFE_SEED : load_val;
            default:   nxt_d.lfsr = cur_q.lfsr;
        endcase
        nxt_d.hit = (nxt_d.lfsr == SAFE_SEED);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q.lfsr <= SAFE_SEED;
            cur_q.hit  <= 1'b1;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign state   = cur_q.lfsr;
    assign at_seed = cur_q.hit;
endmodule

// File: rtl/lfsr_updown_ctr_chk.sv
module lfsr_updown_ctr_chk #(
    parameter int           W    = 16,
    parameter logic [W-1:0] SEED = 16'h0001
) (
    input logic         clk,
    input logic         rst,
    input logic         en,
    input logic         dir_up,
    input logic         load,
    input logic [W-1:0] load_val,
    input logic [W-1:0] state,
    input logic         at_seed
);
    // R1 R10
    reset_seed_chk: assert property (@(posedge clk)
        rst |=> (state == SEED && at_seed));

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && !en) |=> ($stable(state) && $stable(at_seed)));

    // R3
    up_shift_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && en && dir_up) |=> (state[W-1:1] == $past(state[W-2:0])));

    // R4
    down_shift_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && en && !dir_up) |=> (state[W-2:0] == $past(state[W-1:1])));

    // R7
    load_value_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> (state == (($past(load_val) == '0) ? SEED : $past(load_val))));

    // R8
    no_lockup_chk: assert property (@(posedge clk) disable iff (rst)
        state != '0);

    // R9
    seed_flag_chk: assert property (@(posedge clk) disable iff (rst)
        at_seed == (state == SEED));
endmodule

bind lfsr_updown_ctr lfsr_updown_ctr_chk #(.W(W), .SEED(SAFE_SEED)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .dir_up   (dir_up),
    .load     (load),
    .load_val (load_val),
    .state    (state),
    .at_seed  (at_seed)
);

// File: tb/lfsr_updown_ctr_test.sv
module lfsr_updown_ctr_test;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         en = 1'b0;
    logic         dir_up = 1'b1;
    logic         load = 1'b0;
    logic [W-1:0] load_val = '0;
    logic [W-1:0] state;
    logic         at_seed;

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;
    logic [W-1:0] model = 16'h0001;

    int fwd_taps[$] = '{15, 14, 12, 3};

    always #10 clk = ~clk;

    lfsr_updown_ctr uut (
        .clk(clk), .rst(rst), .en(en), .dir_up(dir_up),
        .load(load), .load_val(load_val), .state(state), .at_seed(at_seed)
    );

    function automatic logic [W-1:0] ref_up(input logic [W-1:0] v);
        logic b = 1'b0;
        foreach (fwd_taps[k]) b ^= v[fwd_taps[k]];
        return {v[W-2:0], b};
    endfunction

    // Rebuild the lost top bit: new bit0 of the forward step sits in v[0].
    function automatic logic [W-1:0] ref_down(input logic [W-1:0] v);
        logic b = v[0];
        foreach (fwd_taps[k]) if (fwd_taps[k] != W-1) b ^= v[fwd_taps[k]+1];
        return {b, v[W-1:1]};
    endfunction

    task automatic check(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
        compared++;
        if (got !== exp) begin
            mismatched++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic compare_all(input string req);
        check(req, state, model);
        check({req, "/R9"}, {15'd0, at_seed}, {15'd0, model == 16'h0001});
    endtask

    // Drive at negedge, update model, sample at next negedge.
    task automatic step(input logic r, input logic ld, input logic [W-1:0] lv,
                        input logic e, input logic up, input string req);
        rst = r; load = ld; load_val = lv; en = e; dir_up = up;
        if (r) model = 16'h0001;
        else if (ld) model = (lv == '0) ? 16'h0001 : lv;
        else if (e) model = up ? ref_up(model) : ref_down(model);
        @(posedge clk);
        @(negedge clk);
        compare_all(req);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    endtask

    initial begin
        #(20 * 190000);
        mismatched++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        @(negedge clk);
        // R1 reset state
        step(1, 0, '0, 0, 1, "R1");
        step(0, 0, '0, 0, 1, "R2");
        // R3 forward steps from seed
        for (int i = 0; i < 20; i++) step(0, 0, '0, 1, 1, "R3");
        // R2 hold with direction toggling
        for (int i = 0; i < 6; i++) step(0, 0, 16'hFFFF, 0, i[0], "R2");
        // R4 backward steps through the seed and beyond
        for (int i = 0; i < 30; i++) step(0, 0, '0, 1, 0, "R4");
        // R7 load, overriding enable
        step(0, 1, 16'hACE1, 1, 1, "R7");
        // R5 N up then N down returns to start
        for (int i = 0; i < 300; i++) step(0, 0, '0, 1, 1, "R5");
        for (int i = 0; i < 300; i++) step(0, 0, '0, 1, 0, "R5");
        check("R5", state, 16'hACE1);
        // R7 R8 zero load is replaced by the seed
        step(0, 1, 16'h0000, 0, 0, "R7");
        check("R8", state, 16'h0001);
        // R4 backward from an all-ones load
        step(0, 1, 16'hFFFF, 0, 1, "R7");
        for (int i = 0; i < 10; i++) step(0, 0, '0, 1, 0, "R4");
        // Mixed random stimulus
        for (int i = 0; i < 400; i++) begin
            logic [31:0] r = $urandom;
            step(0, r[7:0] == 8'd0, r[31:16], r[8], r[9], "R3");
        end
        // R10 reset wins over load
        step(1, 1, 16'h1234, 1, 1, "R10");
        // R6 period from seed
        begin
            int first_ret = -1;
            for (int k = 1; k <= 65535; k++) begin
                step(0, 0, '0, 1, 1, "R6");
                if (at_seed && first_ret < 0) first_ret = k;
            end
            check("R6", first_ret[15:0], 16'hFFFF);
            check("R6", {15'd0, first_ret == 65535}, 16'd1);
        end
        finish_run();
    end
endmodule